// File: doc/BRIEF.md
# Ready/Acknowledge Word Handoff Pair

This block moves data words from a producing state machine to a consuming state machine using a two-way level handshake. The producer loads a word from its input port and raises a ready level. It keeps that level and the word on the link until the consumer agrees to take it. The consumer's acknowledge is a plain AND of the producer's ready and the consumer's own accepting state. No register sits in that path. Both machines therefore see the same single cycle as the moment of transfer.

The producer watches acknowledge in the same cycle it is raised. When the word is taken, the producer either drops ready in the next cycle or, if a new word is offered, loads that word and keeps ready high. A held-high ready after an acknowledged cycle therefore counts as a fresh transfer. When neither side stalls, the link carries one word per clock. The consumer puts each captured word on an output with a one-cycle valid strobe.

Stalls are injected on the producer side by withholding the input valid, and on the consumer side by a stall input. The stall input is sampled into the consumer's accepting state.

Top module: `handoffLink`

## Requirements
- R1: A synchronous active-high `rst` leaves `linkReady`, `linkAck` and `outValid` low in the cycle after the reset edge.
- R2: `linkAck` is high exactly in cycles where `linkReady` is high and the consumer is accepting, so a transfer never completes while `linkReady` is low.
- R3: The consumer is accepting in a cycle exactly when `rdStall` was low at the previous rising edge and no reset was applied at that edge.
- R4: `inTaken` is high exactly when `inValid` is high and either `linkReady` is low or `linkAck` is high; the word on `inData` is consumed in that cycle.
- R5: After a cycle with `inTaken` high, `linkReady` is high in the next cycle and `linkData` equals the word that was taken.
- R6: While `linkReady` is high and `linkAck` is low, `linkReady` stays high and `linkData` stays unchanged in the next cycle.
- R7: After a cycle with `linkAck` high and `inTaken` low, `linkReady` is low in the next cycle.
- R8: With `inValid` held high and `rdStall` held low, a new word is acknowledged in every cycle once the link is filled.
- R9: After a cycle with `linkAck` high, `outValid` is high for one cycle and `outData` equals the `linkData` value of the acknowledged cycle; otherwise `outValid` is low.
- R10: Every word taken on `inData` appears on `outData` exactly once, in the order taken, under any pattern of stalls on both sides.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A new word is offered on inData |
| inData | input | DATA_W | Word offered to the producer |
| inTaken | output | 1 | The offered word is consumed this cycle |
| rdStall | input | 1 | Consumer refuses transfers from the next cycle on |
| outValid | output | 1 | One-cycle strobe for a received word |
| outData | output | DATA_W | Received word |
| linkReady | output | 1 | Producer holds a word on the link |
| linkAck | output | 1 | Combinational acknowledge of the link word |
| linkData | output | DATA_W | Word currently on the link |

## Verification
A producer stuck in the wrong state shows up at the ports within one cycle. It either drops `linkReady` with no acknowledge, or it keeps `linkReady` high after an acknowledge with no new word, and either case differs from the cycle-by-cycle model at once. A wrong consumer state shows in the same cycle as an acknowledge that does not match the ready-and-accepting expectation. It then shows one cycle later as a missing or extra `outValid`. Lost or duplicated words are caught at the next received word, which the sequence-numbered scoreboard compares.

// File: rtl/linkPkg.sv
package linkPkg;
  typedef enum logic {WR_IDLE = 1'b0, WR_WAIT = 1'b1} wrStateT;
  typedef enum logic {RD_HOLD = 1'b0, RD_ACCEPT = 1'b1} rdStateT;

  typedef struct packed {
    logic load;
  } wrStrobeT;

  typedef struct packed {
    logic capture;
  } rdStrobeT;
endpackage

// File: rtl/linkWriterCtl.sv
module linkWriterCtl
  import linkPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     linkAck,
  output wrStrobeT strobe,
  output logic     linkReady,
  output logic     inTaken
);
  wrStateT state, stateNext;

  // A word may be taken when the link is free or is being emptied this cycle.
  always_comb begin
    inTaken   = inValid && ((state == WR_IDLE) || linkAck);
    stateNext = state;
    if (inTaken)      stateNext = WR_WAIT;
    else if (linkAck) stateNext = WR_IDLE;
    strobe.load = inTaken;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= WR_IDLE;
    else     state <= stateNext;
  end

  assign linkReady = (state == WR_WAIT);
endmodule

// File: rtl/linkWriterDp.sv
module linkWriterDp
  import linkPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  wrStrobeT          strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] linkData
);
  always_ff @(posedge clk) begin
    if (strobe.load) linkData <= inData;
  end
endmodule

// File: rtl/linkReaderCtl.sv
module linkReaderCtl
  import linkPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rdStall,
  input  logic     linkReady,
  output logic     linkAck,
  output rdStrobeT strobe
);
  rdStateT state;

  always_ff @(posedge clk) begin
    if (rst)          state <= RD_HOLD;
    else if (rdStall) state <= RD_HOLD;
    else              state <= RD_ACCEPT;
  end

  // Unregistered: both sides agree on the transfer cycle.
  always_comb begin
    linkAck        = linkReady && (state == RD_ACCEPT);
    strobe.capture = linkAck;
  end
endmodule

// File: rtl/linkReaderDp.sv
module linkReaderDp
  import linkPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  rdStrobeT          strobe,
  input  logic [DATA_W-1:0] linkData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strobe.capture;
    if (strobe.capture) outData <= linkData;
  end
endmodule

// File: rtl/handoffLink.sv
module handoffLink
  import linkPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inTaken,
  input  logic              rdStall,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              linkReady,
  output logic              linkAck,
  output logic [DATA_W-1:0] linkData
);
  wrStrobeT wrStrobe;
  rdStrobeT rdStrobe;

  linkWriterCtl uWrCtl (
    .clk(clk), .rst(rst), .inValid(inValid), .linkAck(linkAck),
    .strobe(wrStrobe), .linkReady(linkReady), .inTaken(inTaken)
  );

  linkWriterDp #(.DATA_W(DATA_W)) uWrDp (
    .clk(clk), .strobe(wrStrobe), .inData(inData), .linkData(linkData)
  );

  linkReaderCtl uRdCtl (
    .clk(clk), .rst(rst), .rdStall(rdStall), .linkReady(linkReady),
    .linkAck(linkAck), .strobe(rdStrobe)
  );

  linkReaderDp #(.DATA_W(DATA_W)) uRdDp (
    .clk(clk), .rst(rst), .strobe(rdStrobe), .linkData(linkData),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/handoffLinkChk.sv
module handoffLinkChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inTaken,
  input logic              rdStall,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              linkReady,
  input logic              linkAck,
  input logic [DATA_W-1:0] linkData
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!linkReady && !outValid));

  assert_accept_after_unstall_R3: assert property (@(posedge clk) disable iff (rst)
    (!rdStall ##1 linkReady) |-> linkAck);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (linkReady && !linkAck) |=> (linkReady && $stable(linkData)));

  assert_ready_after_take_R5: assert property (@(posedge clk) disable iff (rst)
    inTaken |=> linkReady);

  assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (linkAck && !inTaken) |=> !linkReady);

  assert_capture_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    linkAck |=> (outValid && outData == $past(linkData)));

  assert_no_spurious_out_R9: assert property (@(posedge clk) disable iff (rst)
    !linkAck |=> !outValid);
endmodule

bind handoffLink handoffLinkChk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .inTaken(inTaken), .rdStall(rdStall),
  .outValid(outValid), .outData(outData), .linkReady(linkReady),
  .linkAck(linkAck), .linkData(linkData)
);

// File: tb/tb_handoffLink.sv
`timescale 1ns/1ps
module tb_handoffLink;
  localparam int DATA_W = 16;
  localparam int NVEC = 40;
  // Each entry: {inValid, rdStall}
  localparam logic [1:0] VEC [0:NVEC-1] = '{
    2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b01, 2'b01, 2'b11, 2'b11, 2'b10,
    2'b10, 2'b10, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b00, 2'b00, 2'b10,
    2'b11, 2'b11, 2'b11, 2'b00, 2'b10, 2'b10, 2'b01, 2'b01, 2'b00, 2'b10,
    2'b11, 2'b10, 2'b11, 2'b10, 2'b00, 2'b00, 2'b01, 2'b10, 2'b10, 2'b00
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic rdStall = 1'b1;
  logic inTaken, outValid, linkReady, linkAck;
  logic [DATA_W-1:0] outData, linkData;

  handoffLink #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inTaken(inTaken),
    .rdStall(rdStall), .outValid(outValid), .outData(outData),
    .linkReady(linkReady), .linkAck(linkAck), .linkData(linkData)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  // Bench model, built from the requirements
  logic expReady = 1'b0, expAcc = 1'b0, pendValid = 1'b0;
  logic [DATA_W-1:0] heldWord = '0, pendWord = '0;
  logic [DATA_W-1:0] nextWord = 16'h0100, recvWord = 16'h0100;
  int ackRun = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    expReady = 1'b0; expAcc = 1'b0; pendValid = 1'b0;
  endtask

  // Drive in the low phase, sample, then advance the model over the edge.
  task automatic step(input logic v, input logic s);
    logic eAck, eTaken;
    @(negedge clk);
    inValid = v; rdStall = s; inData = nextWord;
    #1;
    eAck = expReady && expAcc;
    eTaken = v && (!expReady || eAck);
    chk(linkReady == expReady, "R5/R6/R7 linkReady", linkReady, expReady);
    chk(linkAck == eAck, "R2/R3 linkAck", linkAck, eAck);
    chk(inTaken == eTaken, "R4 inTaken", inTaken, eTaken);
    if (expReady) chk(linkData == heldWord, "R5/R6 linkData", linkData, heldWord);
    chk(outValid == pendValid, "R9 outValid", outValid, pendValid);
    if (pendValid) begin
      chk(outData == pendWord, "R9 outData", outData, pendWord);
      chk(outData == recvWord, "R10 order", outData, recvWord);
      recvWord = recvWord + 1'b1;
    end
    ackRun = eAck ? ackRun + 1 : 0;
    @(posedge clk);
    pendValid = eAck;
    pendWord = heldWord;
    if (eTaken) begin
      heldWord = nextWord; expReady = 1'b1; nextWord = nextWord + 1'b1;
    end else if (eAck) expReady = 1'b0;
    expAcc = !s;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(linkReady == 1'b0, "R1 ready after reset", linkReady, 0);
    chk(linkAck == 1'b0, "R1 ack after reset", linkAck, 0);
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    modelReset();
    // rdStall was high during reset, so the reader is not accepting
    for (int i = 0; i < NVEC; i++) step(VEC[i][1], VEC[i][0]);

    // Directed R8: continuous stream, one word per cycle once filled
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    chk(ackRun >= 10, "R8 back-to-back run", ackRun, 10);

    // Directed R7: stop supply, ready must drop after final ack
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(linkReady == 1'b0, "R7 drained", linkReady, 0);

    // Directed R2: producer holds, consumer stalled for a long time
    step(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // Random stalls on both sides, R10 scoreboard
    for (int i = 0; i < 2000; i++) step(($urandom % 3) != 0, ($urandom % 4) == 0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);
    chk(recvWord == nextWord, "R10 all words received", recvWord, nextWord);

    // Directed R1: reset in mid-stream
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    @(negedge clk); rst = 1'b1; inValid = 1'b1; rdStall = 1'b0;
    @(posedge clk);
    @(negedge clk); rst = 1'b0; inValid = 1'b0; rdStall = 1'b1;
    #1;
    chk(linkReady == 1'b0, "R1 ready after mid reset", linkReady, 0);
    chk(outValid == 1'b0, "R1 outValid after mid reset", outValid, 0);
    chk(linkAck == 1'b0, "R1 ack after mid reset", linkAck, 0);
    modelReset();
    recvWord = nextWord;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule